// File: doc/BRIEF.md
# Quad Word-Read Flash Responder

This block is the device-side front end of a serial flash that answers the quad word-read command. The host drives a serial clock, an active-low select and four bidirectional IO lines. The command byte arrives one bit per clock on IO line 0. The read address and a mode byte then arrive one nibble per clock on all four lines. After two turnaround clocks the responder drives the requested bytes back as nibbles. It fetches each byte from a simple synchronous byte-read memory port. All other commands leave the responder passive until the select is raised.

The mode byte can place the responder in a continuous-read state that persists across select cycles. In that state the next transaction skips the command byte and starts directly with the address, which shortens each random access by eight clocks. A quad-enable configuration input must be set for the responder to act at all.

The serial clock, select and IO inputs are assumed to be already synchronous to the system clock `clk`. Each half period of the serial clock must last at least four `clk` cycles. The responder finds the serial clock edges by comparing successive samples of it.

Top module: `qwr_responder`

## Requirements
- R1: After reset `io_oe` is 0, `mem_rd_en` is 0, and the continuous-read state is clear, so the first transaction must start with a command byte.
- R2: A transaction in command form is served only when the first 8 rising serial clock edges carry 8'hE7 on `io_in[0]` (most significant bit first) and `quad_en` is 1. Otherwise `io_oe` stays 0 and no memory read is issued until `spi_cs_n` rises.
- R3: The address arrives as 6 nibbles, most significant nibble first, with `io_in[3]` as each nibble's top bit. The first byte returned is memory content at that address.
- R4: An address whose bit 0 is 1 makes the transaction passive: there is no output and no read. It also clears the continuous-read state.
- R5: The mode byte arrives as 2 nibbles. If the first nibble's bits 1:0 equal 2'b10 (mode bits 5:4 = 10), the next transaction starts with address nibbles and has no command byte. Any other value returns the responder to command form.
- R6: `io_oe` stays 0 through the command, address, mode and two dummy clocks. All four enables rise together at the falling edge of the second dummy clock, and the first nibble is valid there.
- R7: One nibble is driven per serial clock, upper nibble first. The address advances by one after each byte and wraps from 24'hFFFFFF to 24'h000000. Each memory read is a single-cycle `mem_rd_en` pulse.
- R8: While `spi_cs_n` is high, `io_oe` is 0, and it drops within 2 `clk` cycles of `spi_cs_n` rising. A partly sent transaction is discarded, and the next transaction begins afresh with the continuous-read state preserved.
- R9: Inputs are taken on rising serial clock edges. `io_out` changes only after falling serial clock edges, so it holds steady while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| quad_en | input | 1 | Quad-enable configuration bit |
| spi_sclk | input | 1 | Serial clock from host, synchronous to clk |
| spi_cs_n | input | 1 | Active-low select from host |
| io_in | input | 4 | Input side of the four IO lines |
| io_out | output | 4 | Output side of the four IO lines |
| io_oe | output | 4 | Output enables of the four IO lines |
| mem_rd_en | output | 1 | Byte read request, one cycle |
| mem_addr | output | 24 | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after the request is sampled |

## Verification
The hardest situation to reach is the continuous-read state, because it exists only between transactions. It can be changed only by a mode byte or an invalid address sent earlier. The stimulus therefore chains transactions so that each test builds on the flag left by the previous one:
- a mode byte that sets the flag, followed by a command-less read;
- a command-less read with an odd address, which must clear the flag;
- a read cut off by the select in mid-data, which must keep the flag.

The reference model carries the flag across transactions to choose the expected form of each one.

// File: rtl/qwr_pkg.sv
// Shared types and constants of the quad word-read responder.
// Assumes the command byte is always eight serial clocks long.
package qwr_pkg;
    localparam int CMD_CLKS = 8;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_IDLE
    } qwr_phase_e;
endpackage

// File: rtl/qwr_edge_det.sv
// Finds rising and falling edges of the host serial clock by comparing it
// with its previous sample. Assumes the serial clock is synchronous to clk.
module qwr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise_o,
    output logic fall_o
);
    logic sclk_q;

    // Hold the previous serial clock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    // Edge pulses last one clk cycle.
    always_comb begin
        rise_o = sclk_i & ~sclk_q;
        fall_o = ~sclk_i & sclk_q;
    end
endmodule

// File: rtl/qwr_sequencer.sv
// Tracks the phases of one transaction on rising serial clock edges:
// command, address, mode, dummy and data. It keeps the continuous-read
// flag across select cycles. Assumes rise_i is a one-cycle pulse.
module qwr_sequencer
    import qwr_pkg::*;
#(
    parameter int          ADDR_W     = 24,
    parameter int          DUMMY_CLKS = 2,
    parameter logic [7:0]  CMD_CODE   = 8'hE7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              quad_en_i,
    input  logic              rise_i,
    input  logic [3:0]        io_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic              in_data_o,
    output logic              passive_o
);
    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int CNT_MAX   = (CMD_CLKS > ADDR_NIBS) ? CMD_CLKS : ADDR_NIBS;
    localparam int CNT_LIM   = (CNT_MAX > DUMMY_CLKS) ? CNT_MAX : DUMMY_CLKS;
    localparam int CNT_W     = $clog2(CNT_LIM) + 1;

    qwr_phase_e        phase;
    logic [CNT_W-1:0]  cnt;
    logic [CMD_CLKS-2:0] cmd_sh;
    logic [ADDR_W-1:0] addr_sh;
    logic [1:0]        mode_sel;
    logic              cont;
    logic [CMD_CLKS-1:0] cmd_nxt;
    logic [ADDR_W-1:0] addr_nxt;

    // Next values of the command and address shifters.
    always_comb begin
        cmd_nxt  = {cmd_sh, io_i[0]};
        addr_nxt = {addr_sh[ADDR_W-5:0], io_i};
    end

    // Phase sequencing, field capture and continuous-read flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_CMD;
            cnt      <= '0;
            cmd_sh   <= '0;
            addr_sh  <= '0;
            mode_sel <= '0;
            cont     <= 1'b0;
        end else if (cs_n_i) begin
            phase <= (cont && quad_en_i) ? PH_ADDR : PH_CMD;
            cnt   <= '0;
        end else if (rise_i) begin
            case (phase)
                PH_CMD: begin
                    cmd_sh <= cmd_nxt[CMD_CLKS-2:0];
                    if (cnt == CNT_W'(CMD_CLKS - 1)) begin
                        cnt   <= '0;
                        phase <= (cmd_nxt == CMD_CODE && quad_en_i) ? PH_ADDR : PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    addr_sh <= addr_nxt;
                    if (cnt == CNT_W'(ADDR_NIBS - 1)) begin
                        cnt <= '0;
                        if (addr_nxt[0]) begin
                            phase <= PH_IDLE;
                            cont  <= 1'b0;
                        end else begin
                            phase <= PH_MODE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_MODE: begin
                    if (cnt == '0) begin
                        mode_sel <= io_i[1:0];
                        cnt      <= cnt + 1'b1;
                    end else begin
                        cont  <= (mode_sel == 2'b10);
                        cnt   <= '0;
                        phase <= PH_DUMMY;
                    end
                end
                PH_DUMMY: begin
                    if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
                        cnt   <= '0;
                        phase <= PH_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // The first byte is fetched as the mode byte completes.
    always_comb begin
        start_o      = !cs_n_i && rise_i && (phase == PH_MODE) && (cnt != '0);
        start_addr_o = addr_sh;
        in_data_o    = (phase == PH_DATA);
        passive_o    = (phase == PH_IDLE);
    end
endmodule

// File: rtl/qwr_drive.sv
// Fetches bytes over the memory port and drives them as nibbles on falling
// serial clock edges. Assumes a serial half period of at least four clk
// cycles, so that a fetched byte lands before the nibble that needs it.
module qwr_drive #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              in_data_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [3:0]        io_out_o,
    output logic [3:0]        io_oe_o
);
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        cur;
    logic              half;
    logic              land;
    logic              next_fetch;

    // The next byte is requested as the lower nibble goes out.
    always_comb next_fetch = !cs_n_i && in_data_i && fall_i && half;

    // Issue single-cycle reads and advance the byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_en_o <= 1'b0;
            mem_addr_o  <= '0;
            ptr         <= '0;
            land        <= 1'b0;
        end else begin
            mem_rd_en_o <= 1'b0;
            land        <= mem_rd_en_o;
            if (start_i) begin
                mem_rd_en_o <= 1'b1;
                mem_addr_o  <= start_addr_i;
                ptr         <= start_addr_i + 1'b1;
            end else if (next_fetch) begin
                mem_rd_en_o <= 1'b1;
                mem_addr_o  <= ptr;
                ptr         <= ptr + 1'b1;
            end
        end
    end

    // Capture returned bytes and drive nibbles with their enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= '0;
            half     <= 1'b0;
            io_out_o <= '0;
            io_oe_o  <= '0;
        end else begin
            if (land) cur <= mem_rdata_i;
            if (cs_n_i) begin
                io_oe_o <= '0;
                half    <= 1'b0;
            end else if (fall_i && in_data_i) begin
                io_oe_o  <= '1;
                io_out_o <= half ? cur[3:0] : cur[7:4];
                half     <= ~half;
            end
        end
    end
endmodule

// File: rtl/qwr_responder.sv
// Top of the quad word-read responder. Joins the edge detector, the
// phase sequencer and the fetch/drive stage. Assumes all serial inputs
// are synchronous to clk.
module qwr_responder #(
    parameter int         ADDR_W     = 24,
    parameter int         DUMMY_CLKS = 2,
    parameter logic [7:0] CMD_CODE   = 8'hE7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quad_en,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);
    logic              rise;
    logic              fall;
    logic              start;
    logic [ADDR_W-1:0] start_addr;
    logic              seq_in_data;
    logic              seq_passive;

    qwr_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (spi_sclk),
        .rise_o (rise),
        .fall_o (fall)
    );

    qwr_sequencer #(
        .ADDR_W     (ADDR_W),
        .DUMMY_CLKS (DUMMY_CLKS),
        .CMD_CODE   (CMD_CODE)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_i       (spi_cs_n),
        .quad_en_i    (quad_en),
        .rise_i       (rise),
        .io_i         (io_in),
        .start_o      (start),
        .start_addr_o (start_addr),
        .in_data_o    (seq_in_data),
        .passive_o    (seq_passive)
    );

    qwr_drive #(
        .ADDR_W (ADDR_W)
    ) u_drv (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_i       (spi_cs_n),
        .fall_i       (fall),
        .start_i      (start),
        .start_addr_i (start_addr),
        .in_data_i    (seq_in_data),
        .mem_rdata_i  (mem_rdata),
        .mem_rd_en_o  (mem_rd_en),
        .mem_addr_o   (mem_addr),
        .io_out_o     (io_out),
        .io_oe_o      (io_oe)
    );
endmodule

// File: rtl/qwr_checker.sv
// Protocol checks on the quad word-read responder, attached by bind.
module qwr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic [3:0] io_oe,
    input logic [3:0] io_out,
    input logic       mem_rd_en,
    input logic       in_data,
    input logic       passive
);
    // R8
    cs_high_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && cs_n) |-> (io_oe == 4'h0));

    // R9
    out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sclk) |-> $stable(io_out));

    // R2
    passive_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        passive |-> !mem_rd_en);

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R6
    oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_oe[0]) |-> in_data);

    // R6
    oe_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'h0) || (io_oe == 4'hF));
endmodule

bind qwr_responder qwr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .io_oe     (io_oe),
    .io_out    (io_out),
    .mem_rd_en (mem_rd_en),
    .in_data   (seq_in_data),
    .passive   (seq_passive)
);

// File: tb/sim_qwr_responder.sv
module sim_qwr_responder;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        quad_en = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic [3:0]  io_in = 4'h0;
    logic [3:0]  io_out;
    logic [3:0]  io_oe;
    logic        mem_rd_en;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;

    int n_checks = 0;
    int n_err = 0;
    int n_reads = 0;
    bit model_cont = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    qwr_responder u0 (
        .clk(clk), .rst_n(rst_n), .quad_en(quad_en), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
    endfunction

    // Memory stimulus: one-cycle synchronous byte read.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= pat(mem_addr);
            n_reads++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One serial clock: present din, check before rise and during high.
    task automatic sclk_cycle(input logic [3:0] din, input bit exp_oe,
                              input logic [3:0] exp_nib, input string req);
        io_in = din;
        repeat (H - 1) @(negedge clk);
        chk(io_oe == (exp_oe ? 4'hF : 4'h0), exp_oe ? req : "R6", "io_oe", io_oe, exp_oe ? 4'hF : 4'h0);
        if (exp_oe) chk(io_out == exp_nib, req, "io_out", io_out, exp_nib);
        spi_sclk = 1'b1;
        repeat (H - 1) @(negedge clk);
        if (exp_oe) chk(io_out == exp_nib, "R9", "io_out held while high", io_out, exp_nib);
        @(negedge clk);
        spi_sclk = 1'b0;
        @(negedge clk);
    endtask

    // One transaction; the model decides its form and expected result.
    task automatic txn(input logic [7:0] cmd, input logic [23:0] a,
                       input logic [7:0] mode, input int nibs, input string req);
        bit cmd_form = !(model_cont && quad_en);
        bit ok = 1'b1;
        int reads0 = n_reads;
        logic [23:0] ba;
        logic [7:0] b;
        if (cmd_form) ok = (cmd == 8'hE7) && quad_en;
        if (ok && a[0]) begin
            ok = 1'b0;
            model_cont = 1'b0;
        end
        spi_cs_n = 1'b0;
        repeat (2) @(negedge clk);
        if (cmd_form)
            for (int i = 7; i >= 0; i--) sclk_cycle({3'b000, cmd[i]}, 1'b0, 4'h0, req);
        for (int i = 5; i >= 0; i--) sclk_cycle(a[i*4 +: 4], 1'b0, 4'h0, req);
        sclk_cycle(mode[7:4], 1'b0, 4'h0, req);
        sclk_cycle(mode[3:0], 1'b0, 4'h0, req);
        sclk_cycle(4'h0, 1'b0, 4'h0, req);
        sclk_cycle(4'h0, 1'b0, 4'h0, req);
        for (int k = 0; k < nibs; k++) begin
            ba = a + 24'(k / 2);
            b = pat(ba);
            sclk_cycle(4'h0, ok, (k % 2 == 0) ? b[7:4] : b[3:0], req);
        end
        if (ok) model_cont = (mode[5:4] == 2'b10);
        spi_cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(io_oe == 4'h0, "R8", "io_oe after select high", io_oe, 0);
        if (!ok) chk(n_reads == reads0, req, "reads in passive transaction", n_reads - reads0, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        spi_cs_n = 1'b1;
        spi_sclk = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        model_cont = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk(io_oe == 4'h0, "R1", "io_oe after reset", io_oe, 0);
        chk(mem_rd_en == 1'b0, "R1", "mem_rd_en after reset", mem_rd_en, 0);
        quad_en = 1'b1;
        // R3 R7: plain read in command form
        txn(8'hE7, 24'h000100, 8'hFF, 8, "R3");
        // R2: quad enable clear leaves the responder passive
        quad_en = 1'b0;
        txn(8'hE7, 24'h000200, 8'hFF, 4, "R2");
        quad_en = 1'b1;
        // R2: another command code is ignored
        txn(8'hEB, 24'h000200, 8'hFF, 4, "R2");
        // R5: mode sets the continuous state, then a command-less read
        txn(8'hE7, 24'h123456, 8'h20, 4, "R5");
        txn(8'h00, 24'h00ABC0, 8'hA5, 6, "R5");
        // R4: odd address in continuous form is passive and clears the state
        txn(8'h00, 24'h000201, 8'h20, 4, "R4");
        // R7: wrap at the top of the address space
        txn(8'hE7, 24'hFFFFFE, 8'h00, 6, "R7");
        // R8: cut off in mid-data, continuous state kept
        txn(8'hE7, 24'h000040, 8'h20, 3, "R8");
        txn(8'h00, 24'h000080, 8'h10, 4, "R8");
        // R5: a mode value with other bits returns to command form
        txn(8'hE7, 24'h000300, 8'hCF, 4, "R5");
        // R1: reset clears the continuous state
        txn(8'hE7, 24'h000400, 8'h20, 2, "R5");
        quad_en = 1'b1;
        do_reset();
        txn(8'hE7, 24'h000500, 8'hFF, 4, "R1");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog run did not finish");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end
endmodule